// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block answers as a nonvolatile-memory device on an SPI bus in mode 0. Each transaction opens when the chip select goes low and begins with an 8-bit instruction on the serial input. The block supports six instructions: read data, write data, read status, write status, set the write enable latch and clear it. The storage is an internal byte array of `2**ADDR_W` bytes, written in the style that infers block RAM. Each byte is stored at once, with no programming delay, so the busy flag always reads 0.

All logic runs on one system clock. The serial clock, chip select and serial input are taken as already synchronised to that clock, and their edges are found by comparing each with its value one clock earlier. Writes pass three guards: the write enable latch, a block-protect level that fences off an upper part of the array, and a lock on the status register. That lock is formed from a status bit and a hardware pin.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset the status register reads 0x00: latch clear, protection level 0, lock bit 0, busy 0.
- R2: Instruction 0x06 sets the latch only when chip select rises with exactly 8 serial clocks in the frame. If further clocks follow in the same frame, the latch stays clear and a write that follows in that frame stores nothing.
- R3: `so_oe` stays low while an instruction, address or write data is being received, and whenever chip select is high.
- R4: Instruction 0x04 clears the latch.
- R5: Read (0x03) takes a 16-bit address MSB first. Only the low `ADDR_W` bits are used, so address 0xFC00 reads location 0.
- R6: During a read, each further 8 clocks shift out the next byte, MSB first, with `so` changing after the falling SCK edge. The address wraps from the top location to 0.
- R7: Write (0x02), followed by a 16-bit address and data bytes, stores each complete byte only while the latch is 1. The address increments after each byte and wraps.
- R8: The protection level in status bits 3:2 selects the region that cannot be written: 00 none, 01 upper quarter, 10 upper half, 11 all.
- R9: Write status (0x01) takes one byte and updates only bit 7 (lock) and bits 3:2 (level). It is accepted only when the latch is 1 and either the lock bit is 0 or `hw_lock_n` is high. Otherwise it is ignored.
- R10: When chip select rises after an accepted status write, or after at least one complete write-data byte, the latch is cleared.
- R11: Read status (0x05) returns {lock, 000, level, latch, busy} and repeats that byte for as long as clocks continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hw_lock_n | input | 1 | Low locks the status register when the lock bit is set |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
A wrong latch value appears at the ports at the next read-status transaction, as bit 1 of the returned byte. It also appears as a write that fails or succeeds against expectation, which a later read of that location shows. A wrong address pointer or a wrong protection decode appears as a wrong data byte on the very next byte shifted out, within 8 serial clocks. A fault in instruction or frame tracking shows as a byte taken from the wrong source, or as `so_oe` rising during a receive phase, in the same frame.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_SROUT,
    ST_SRIN,
    ST_IGN
  } ee_state_t;
endpackage

// File: rtl/spi_ee_edges.sv
module spi_ee_edges (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = !cs_n && sck && !sck_q;
  assign sck_fall = !cs_n && !sck && sck_q;
  assign cs_rise  = cs_n && !cs_q;
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_ee_guard.sv
module spi_ee_guard #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    level,
  output logic          hit
);
  always_comb begin
    case (level)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &addr[AW-1:AW-2];
      2'b10:   hit = addr[AW-1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int ADDR_BYTES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hw_lock_n,
  output logic so,
  output logic so_oe
);
  localparam int ALEN = 8 * ADDR_BYTES;
  localparam int CW   = $clog2(ALEN) + 1;
  localparam logic [ADDR_W-1:0] ONE = 1;
  localparam logic [CW-1:0] ALAST = CW'(ALEN - 1);

  ee_state_t st;
  logic [CW-1:0]     bcnt;
  logic [6:0]        rxsh;
  logic [ADDR_W-1:0] ash, ptr;
  logic              is_rd, wel, sr_wpen, arm, wr_done;
  logic [1:0]        sr_bp;
  logic [7:0]        txsh;
  logic [2:0]        ocnt;
  logic              sck_rise, sck_fall, cs_rise;
  logic              hit, mem_we;
  logic [7:0]        rdata, rx_byte, sr_byte, src;
  logic              byte_done, sr_ok;

  spi_ee_edges u_edges (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  spi_ee_guard #(.AW(ADDR_W)) u_guard (
    .addr(ptr), .level(sr_bp), .hit(hit)
  );

  spi_ee_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(rx_byte),
    .raddr(ptr), .rdata(rdata)
  );

  assign rx_byte   = {rxsh, si};
  assign byte_done = sck_rise && (bcnt[2:0] == 3'd7);
  assign mem_we    = (st == ST_WDATA) && byte_done && wel && !hit;
  assign sr_byte   = {sr_wpen, 3'b000, sr_bp, wel, 1'b0};
  assign src       = (st == ST_RDATA) ? rdata : sr_byte;
  assign sr_ok     = wel && (!sr_wpen || hw_lock_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_CMD;
      bcnt    <= '0;
      rxsh    <= '0;
      ash     <= '0;
      ptr     <= '0;
      is_rd   <= 1'b0;
      wel     <= 1'b0;
      sr_wpen <= 1'b0;
      sr_bp   <= 2'b00;
      arm     <= 1'b0;
      wr_done <= 1'b0;
      txsh    <= '0;
      ocnt    <= '0;
      so      <= 1'b0;
      so_oe   <= 1'b0;
    end else if (cs_n) begin
      st      <= ST_CMD;
      bcnt    <= '0;
      ocnt    <= '0;
      so_oe   <= 1'b0;
      arm     <= 1'b0;
      wr_done <= 1'b0;
      if (cs_rise) begin
        if (arm) wel <= 1'b1;
        else if (wr_done) wel <= 1'b0;
      end
    end else begin
      if (sck_rise) begin
        rxsh <= rx_byte[6:0];
        bcnt <= bcnt + 1'b1;
        case (st)
          ST_CMD: if (byte_done) begin
            bcnt <= '0;
            case (rx_byte)
              OP_READ:  begin st <= ST_ADDR; is_rd <= 1'b1; end
              OP_WRITE: begin st <= ST_ADDR; is_rd <= 1'b0; end
              OP_RDSR:  st <= ST_SROUT;
              OP_WRSR:  st <= ST_SRIN;
              OP_WREN:  begin st <= ST_IGN; arm <= 1'b1; end
              OP_WRDI:  begin st <= ST_IGN; wel <= 1'b0; end
              default:  st <= ST_IGN;
            endcase
          end
          ST_ADDR: begin
            ash <= {ash[ADDR_W-2:0], si};
            if (bcnt == ALAST) begin
              ptr  <= {ash[ADDR_W-2:0], si};
              bcnt <= '0;
              st   <= is_rd ? ST_RDATA : ST_WDATA;
            end
          end
          ST_WDATA: if (byte_done) begin
            ptr     <= ptr + ONE;
            wr_done <= 1'b1;
          end
          ST_SRIN: if (byte_done) begin
            st <= ST_IGN;
            if (sr_ok) begin
              sr_wpen <= rx_byte[7];
              sr_bp   <= rx_byte[3:2];
              wr_done <= 1'b1;
            end
          end
          ST_IGN: arm <= 1'b0;
          default: ;
        endcase
      end
      if (sck_fall && (st == ST_RDATA || st == ST_SROUT)) begin
        so_oe <= 1'b1;
        ocnt  <= ocnt + 1'b1;
        if (ocnt == 3'd0) begin
          so   <= src[7];
          txsh <= {src[6:0], 1'b0};
          if (st == ST_RDATA) ptr <= ptr + ONE;
        end else begin
          so   <= txsh[7];
          txsh <= {txsh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_ee_slave_chk.sv
module spi_ee_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       hw_lock_n,
  input logic       so_oe,
  input logic       wel,
  input logic       mem_we,
  input logic [1:0] bp,
  input logic       wpen
);
  // R1: latch clear after reset
  a_r1_reset_wel: assert property (@(posedge clk) rst |=> !wel);
  // R3: output driver off while deselected
  a_r3_oe_off: assert property (@(posedge clk) disable iff (rst) cs_n |=> !so_oe);
  // R2: latch only sets on a chip-select rise
  a_r2_arm_on_cs: assert property (@(posedge clk) disable iff (rst) $rose(wel) |-> $past(cs_n));
  // R7: array writes require the latch
  a_r7_we_needs_wel: assert property (@(posedge clk) disable iff (rst) mem_we |-> wel);
  // R8: full protection blocks every write
  a_r8_full_block: assert property (@(posedge clk) disable iff (rst) mem_we |-> (bp != 2'b11));
  // R9: level changes only under a permitted status write
  a_r9_bp_guard: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> ($past(wel) && (!$past(wpen) || $past(hw_lock_n))));
  a_r9_wpen_guard: assert property (@(posedge clk) disable iff (rst)
    !$stable(wpen) |-> ($past(wel) && (!$past(wpen) || $past(hw_lock_n))));
endmodule

bind spi_ee_slave spi_ee_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .hw_lock_n(hw_lock_n), .so_oe(so_oe),
  .wel(wel), .mem_we(mem_we), .bp(sr_bp), .wpen(sr_wpen)
);

// File: tb/spi_ee_slave_bench.sv
module spi_ee_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hw_lock_n = 1'b1;
  logic so, so_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ee_slave u_spi_ee_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hw_lock_n(hw_lock_n), .so(so), .so_oe(so_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares received bytes against the expected queue
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a === e, t, a, e);
      end
    end
  end

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input bit oe_off_chk, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so;
      if (oe_off_chk) chk(so_oe === 1'b0, tag, {7'd0, so_oe}, 8'h00);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic begin_frame;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_frame;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    logic [7:0] r;
    xbyte(b, r, 1'b0, "");
  endtask

  task automatic expect_rx(input logic [7:0] e, input string tag);
    logic [7:0] r;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    xbyte(8'h00, r, 1'b0, tag);
    act_q.push_back(r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    begin_frame; put(op); end_frame;
  endtask

  task automatic status_is(input logic [7:0] e, input string tag);
    begin_frame; put(8'h05); expect_rx(e, tag); end_frame;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    begin_frame; put(8'h02); put(a[15:8]); put(a[7:0]); put(d); end_frame;
  endtask

  task automatic rd1(input logic [15:0] a, input logic [7:0] e, input string tag);
    begin_frame; put(8'h03); put(a[15:8]); put(a[7:0]); expect_rx(e, tag); end_frame;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 / R3 reset state
    chk(so_oe === 1'b0, "R3 oe idle", {7'd0, so_oe}, 8'h00);
    status_is(8'h00, "R1 reset status");

    // R3: WREN reception with output disabled; R2 latch set after CS rise
    begin_frame; xbyte(8'h06, r, 1'b1, "R3 oe during cmd"); end_frame;
    status_is(8'h02, "R2 wel after wren");
    // R4
    cmd1(8'h04);
    status_is(8'h00, "R4 wrdi clears");

    // R7/R6 burst write with wrap, then R10
    cmd1(8'h06);
    begin_frame; put(8'h02); put(8'h03); put(8'hFE);
    put(8'h11); put(8'h22); put(8'h33); end_frame;
    status_is(8'h00, "R10 wel cleared by write");
    cmd1(8'h06); wr(16'h0300, 8'hEE);
    cmd1(8'h06); wr(16'h02FF, 8'h5A);

    // R6 sequential read with wrap
    begin_frame; put(8'h03); put(8'h03); put(8'hFE);
    expect_rx(8'h11, "R6 seq b0");
    expect_rx(8'h22, "R6 seq b1");
    expect_rx(8'h33, "R6 seq wrap");
    end_frame;
    // R5 upper address bits ignored
    rd1(16'hFC00, 8'h33, "R5 upper bits");

    // R7 write without latch ignored
    wr(16'h0000, 8'h77);
    rd1(16'h0000, 8'h33, "R7 no wel no write");

    // R2 write in same frame as WREN ignored
    begin_frame; put(8'h06); put(8'h02); put(8'h00); put(8'h00); put(8'h99); end_frame;
    status_is(8'h00, "R2 no arm on extra clocks");
    rd1(16'h0000, 8'h33, "R2 no store same frame");

    // R9 status write: lock bit and level 01
    cmd1(8'h06);
    begin_frame; put(8'h01); put(8'hFF); end_frame;
    status_is(8'h8C, "R9 wrsr accepted");
    cmd1(8'h06);
    begin_frame; put(8'h01); put(8'h84); end_frame;
    status_is(8'h84, "R10 wel cleared by wrsr");

    // R8 upper quarter protected
    cmd1(8'h06); wr(16'h0300, 8'h44);
    cmd1(8'h06); wr(16'h02FF, 8'h66);
    rd1(16'h02FF, 8'h66, "R8 below region writable");
    rd1(16'h0300, 8'hEE, "R8 region protected");

    // R9 locked by pin
    hw_lock_n = 1'b0;
    cmd1(8'h06);
    begin_frame; put(8'h01); put(8'h00); end_frame;
    // R11 status repeats
    begin_frame; put(8'h05);
    expect_rx(8'h86, "R9 wrsr ignored when locked");
    expect_rx(8'h86, "R11 status repeats");
    end_frame;
    hw_lock_n = 1'b1;
    begin_frame; put(8'h01); put(8'h00); end_frame;
    status_is(8'h00, "R9 wrsr accepted when unlocked");

    wait (act_q.size() == 0);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule